// File: doc/BRIEF.md
# Parallel Camera Capture

This block takes pixels from an image sensor that drives an 8-bit data bus, a pixel clock and separate vertical and horizontal sync lines. Everything runs on one system clock. The pixel clock and the sync lines are sampled as ordinary inputs, and each selected pixel-clock edge acts as a sample enable. Bytes that arrive while both syncs are active are packed four to a 32-bit word. Each finished word is offered to a downstream FIFO with a single-cycle write strobe.

Along with the data, the block raises single-cycle pulses when a frame starts, when a frame ends, when a line starts and when a line ends. The integrator can configure the following:
- the polarity of each sync line;
- which pixel-clock edge samples the data;
- whether the bytes inside a word are reversed;
- whether capture starts on any sample with vertical sync active, or only on its inactive-to-active transition.

Clearing the enable either stops capture at once or lets the current frame finish. A core-reset pulse forces the capture machinery back to idle, but only while the block is disabled.

Top module: `cam_capture`

## Requirements
- R1: After reset the outputs are low: `wr_en`, `capturing` and all four event pulses are 0, and `wr_data` is 0.
- R2: Within a frame, every sample taken while horizontal sync is active is packed. The first sample of a word goes to bits 7:0, the second to 15:8, the third to 23:16 and the fourth to 31:24. `wr_en` is high for exactly one cycle per completed word. Samples taken while horizontal sync is inactive are not packed.
- R3: With `cfg_swap`=1, the byte order in the word is reversed: the first sample goes to bits 31:24 and the fourth to bits 7:0.
- R4: `cfg_vs_low`=1 makes a low `cam_vsync` mean active, and 0 makes a high level mean active. `cfg_hs_low` does the same for `cam_hsync`.
- R5: `cfg_pclk_fall`=0 samples on rising edges of `cam_pclk`, and 1 samples on falling edges. The opposite edge samples nothing.
- R6: `evt_frame_start` pulses on the sample that enters a frame, and `evt_frame_end` pulses on the first sample with vertical sync inactive. Within a frame, `evt_line_start` pulses on the sample where horizontal sync becomes active and `evt_line_end` on the sample where it becomes inactive. `capturing` is 1 from frame start up to frame end.
- R7: A word left partly filled when a line ends is discarded. The next line starts packing at byte 0.
- R8: With `cfg_start_on_edge`=0 and the block enabled, any sample with vertical sync active starts a frame, even if that sync level was already present before the enable.
- R9: With `cfg_start_on_edge`=1, a frame starts only on a sample where vertical sync is active and the previous sample had it inactive. A sync level that is already active gives no frame start.
- R10: Clearing `cfg_enable` while `cfg_stop_at_frame_end`=0 ends capture on the next cycle. No event pulse is produced, the partial word is dropped, and later samples produce no output.
- R11: Clearing `cfg_enable` while `cfg_stop_at_frame_end`=1 lets the frame in progress keep producing words and events until its frame end. After that, no new frame starts.
- R12: A `core_rst` pulse while `cfg_enable`=0 forces the block to idle on the next cycle, even in the middle of a frame that is being finished. While `cfg_enable`=1, `core_rst` has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cam_pclk | input | 1 | Sensor pixel clock, sampled as data |
| cam_vsync | input | 1 | Vertical sync from sensor |
| cam_hsync | input | 1 | Horizontal sync from sensor |
| cam_data | input | 8 | Pixel byte from sensor |
| cfg_enable | input | 1 | Capture enable |
| cfg_stop_at_frame_end | input | 1 | 1: a cleared enable waits for frame end |
| cfg_start_on_edge | input | 1 | 1: start only on a vertical sync transition |
| cfg_vs_low | input | 1 | Vertical sync active low |
| cfg_hs_low | input | 1 | Horizontal sync active low |
| cfg_pclk_fall | input | 1 | Sample on falling pixel-clock edge |
| cfg_swap | input | 1 | Reverse byte order in the word |
| core_rst | input | 1 | Return to idle, honoured only while disabled |
| wr_data | output | 32 | Packed word |
| wr_en | output | 1 | One-cycle write strobe for `wr_data` |
| capturing | output | 1 | A frame is being captured |
| evt_frame_start | output | 1 | Frame start pulse |
| evt_frame_end | output | 1 | Frame end pulse |
| evt_line_start | output | 1 | Line start pulse |
| evt_line_end | output | 1 | Line end pulse |

## Verification
Sync and data changes are driven together with a pixel-clock transition. The sampler registers them on the next system-clock edge, and words, event pulses and `capturing` appear one edge after that, so every result is due two edges after its stimulus. The bench holds each pixel-clock phase for two cycles and samples all outputs on falling clock edges. Every result has therefore settled before it is read, and the next sample cannot overlap it. Enable and core-reset changes take effect one edge after they are applied. The port checks for R9 to R12 read `capturing` after that edge.

// File: rtl/cam_pkg.sv
package cam_pkg;
    typedef enum logic [0:0] {
        CS_IDLE  = 1'b0,
        CS_FRAME = 1'b1
    } cap_state_e;

    typedef struct packed {
        logic fs;
        logic fe;
        logic ls;
        logic le;
    } cap_events_t;
endpackage

// File: rtl/cam_sync_sampler.sv
module cam_sync_sampler #(
    parameter int PIX_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pclk_i,
    input  logic             vs_i,
    input  logic             hs_i,
    input  logic [PIX_W-1:0] pix_i,
    input  logic             clk_fall,
    input  logic             vs_low,
    input  logic             hs_low,
    output logic             stb_o,
    output logic             vs_act_o,
    output logic             hs_act_o,
    output logic [PIX_W-1:0] pix_o
);
    typedef struct packed {
        logic             pclk_now;
        logic             pclk_old;
        logic             vs;
        logic             hs;
        logic [PIX_W-1:0] pix;
    } smp_t;

    smp_t smp_d, smp_q;

    always_comb begin
        smp_d          = smp_q;
        smp_d.pclk_now = pclk_i;
        smp_d.pclk_old = smp_q.pclk_now;
        smp_d.vs       = vs_i;
        smp_d.hs       = hs_i;
        smp_d.pix      = pix_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) smp_q <= '0;
        else        smp_q <= smp_d;
    end

    // A selected edge: level changed and now sits on the post-edge level
    assign stb_o    = (smp_q.pclk_now != smp_q.pclk_old) && (smp_q.pclk_now == !clk_fall);
    assign vs_act_o = smp_q.vs ^ vs_low;
    assign hs_act_o = smp_q.hs ^ hs_low;
    assign pix_o    = smp_q.pix;
endmodule

// File: rtl/cam_frame_ctrl.sv
module cam_frame_ctrl
    import cam_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        stb_i,
    input  logic        vs_act_i,
    input  logic        hs_act_i,
    input  logic        en_i,
    input  logic        stop_at_end_i,
    input  logic        start_on_edge_i,
    input  logic        core_rst_i,
    output logic        take_o,
    output logic        clr_o,
    output logic        busy_o,
    output cap_events_t ev_o
);
    typedef struct packed {
        cap_state_e  st;
        logic        vs_prev;
        logic        hs_prev;
        cap_events_t ev;
    } ctl_t;

    ctl_t ctl_d, ctl_q;
    logic start_hit;
    logic kill;
    logic in_frame;

    always_comb begin
        ctl_d    = ctl_q;
        ctl_d.ev = '0;
        take_o   = 1'b0;
        clr_o    = 1'b0;

        start_hit = start_on_edge_i ? (vs_act_i && !ctl_q.vs_prev) : vs_act_i;
        kill      = !en_i && (core_rst_i || !stop_at_end_i);

        if (stb_i) begin
            ctl_d.vs_prev = vs_act_i;
            ctl_d.hs_prev = hs_act_i;
        end

        unique case (ctl_q.st)
            CS_IDLE: begin
                if (en_i && stb_i && start_hit) begin
                    ctl_d.st    = CS_FRAME;
                    ctl_d.ev.fs = 1'b1;
                end
            end
            CS_FRAME: begin
                if (stb_i && !vs_act_i) begin
                    ctl_d.st    = CS_IDLE;
                    ctl_d.ev.fe = 1'b1;
                end
            end
            default: ctl_d.st = CS_IDLE;
        endcase

        if (kill) begin
            ctl_d.st    = CS_IDLE;
            ctl_d.ev.fs = 1'b0;
            ctl_d.ev.fe = 1'b0;
        end

        in_frame = (ctl_d.st == CS_FRAME) && stb_i && vs_act_i;
        if (in_frame) begin
            ctl_d.ev.ls = hs_act_i && !ctl_q.hs_prev;
            ctl_d.ev.le = !hs_act_i && ctl_q.hs_prev;
            take_o      = hs_act_i;
        end
        clr_o = (ctl_d.st != CS_FRAME) || ctl_d.ev.ls || ctl_d.ev.le;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '{st: CS_IDLE, vs_prev: 1'b0, hs_prev: 1'b0, ev: '0};
        else        ctl_q <= ctl_d;
    end

    assign busy_o = (ctl_q.st == CS_FRAME);
    assign ev_o   = ctl_q.ev;
endmodule

// File: rtl/cam_word_packer.sv
module cam_word_packer #(
    parameter int PIX_W = 8,
    parameter int LANES = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   take_i,
    input  logic                   clr_i,
    input  logic                   swap_i,
    input  logic [PIX_W-1:0]       pix_i,
    output logic [PIX_W*LANES-1:0] word_o,
    output logic                   we_o
);
    localparam int CNT_W = (LANES > 1) ? $clog2(LANES) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(LANES - 1);

    typedef struct packed {
        logic [CNT_W-1:0]            cnt;
        logic [LANES-1:0][PIX_W-1:0] lanes;
        logic [PIX_W*LANES-1:0]      word;
        logic                        we;
    } pk_t;

    pk_t pk_d, pk_q;
    logic [CNT_W-1:0] base;
    logic [CNT_W-1:0] slot;

    always_comb begin
        pk_d    = pk_q;
        pk_d.we = 1'b0;
        base    = clr_i ? '0 : pk_q.cnt;
        slot    = swap_i ? (LAST - base) : base;
        pk_d.cnt = base;
        if (take_i) begin
            pk_d.lanes[slot] = pix_i;
            if (base == LAST) begin
                pk_d.cnt  = '0;
                pk_d.word = pk_d.lanes;
                pk_d.we   = 1'b1;
            end else begin
                pk_d.cnt = base + CNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pk_q <= '0;
        else        pk_q <= pk_d;
    end

    assign word_o = pk_q.word;
    assign we_o   = pk_q.we;
endmodule

// File: rtl/cam_capture.sv
module cam_capture
    import cam_pkg::*;
#(
    parameter int PIX_W = 8,
    parameter int LANES = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   cam_pclk,
    input  logic                   cam_vsync,
    input  logic                   cam_hsync,
    input  logic [PIX_W-1:0]       cam_data,
    input  logic                   cfg_enable,
    input  logic                   cfg_stop_at_frame_end,
    input  logic                   cfg_start_on_edge,
    input  logic                   cfg_vs_low,
    input  logic                   cfg_hs_low,
    input  logic                   cfg_pclk_fall,
    input  logic                   cfg_swap,
    input  logic                   core_rst,
    output logic [PIX_W*LANES-1:0] wr_data,
    output logic                   wr_en,
    output logic                   capturing,
    output logic                   evt_frame_start,
    output logic                   evt_frame_end,
    output logic                   evt_line_start,
    output logic                   evt_line_end
);
    logic             stb;
    logic             vs_act;
    logic             hs_act;
    logic [PIX_W-1:0] pix;
    logic             take;
    logic             clr;
    cap_events_t      ev;

    cam_sync_sampler #(.PIX_W(PIX_W)) u_smp (
        .clk      (clk),
        .rst_n    (rst_n),
        .pclk_i   (cam_pclk),
        .vs_i     (cam_vsync),
        .hs_i     (cam_hsync),
        .pix_i    (cam_data),
        .clk_fall (cfg_pclk_fall),
        .vs_low   (cfg_vs_low),
        .hs_low   (cfg_hs_low),
        .stb_o    (stb),
        .vs_act_o (vs_act),
        .hs_act_o (hs_act),
        .pix_o    (pix)
    );

    cam_frame_ctrl u_ctl (
        .clk             (clk),
        .rst_n           (rst_n),
        .stb_i           (stb),
        .vs_act_i        (vs_act),
        .hs_act_i        (hs_act),
        .en_i            (cfg_enable),
        .stop_at_end_i   (cfg_stop_at_frame_end),
        .start_on_edge_i (cfg_start_on_edge),
        .core_rst_i      (core_rst),
        .take_o          (take),
        .clr_o           (clr),
        .busy_o          (capturing),
        .ev_o            (ev)
    );

    cam_word_packer #(.PIX_W(PIX_W), .LANES(LANES)) u_pk (
        .clk    (clk),
        .rst_n  (rst_n),
        .take_i (take),
        .clr_i  (clr),
        .swap_i (cfg_swap),
        .pix_i  (pix),
        .word_o (wr_data),
        .we_o   (wr_en)
    );

    assign evt_frame_start = ev.fs;
    assign evt_frame_end   = ev.fe;
    assign evt_line_start  = ev.ls;
    assign evt_line_end    = ev.le;
endmodule

// File: rtl/cam_capture_chk.sv
module cam_capture_chk (
    input logic clk,
    input logic rst_n,
    input logic cfg_enable,
    input logic cfg_stop_at_frame_end,
    input logic core_rst,
    input logic wr_en,
    input logic capturing,
    input logic evt_frame_start,
    input logic evt_frame_end,
    input logic evt_line_start,
    input logic evt_line_end
);
    // R2: samples need a full pixel-clock period, so strobes never repeat back to back
    a_r2_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> !wr_en);

    // R6: a frame cannot open and close on the same sample
    a_r6_frame_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(evt_frame_start && evt_frame_end));

    // R6: line start and line end are mutually exclusive
    a_r6_line_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(evt_line_start && evt_line_end));

    // R6: frame start coincides with the capturing flag
    a_r6_start_busy: assert property (@(posedge clk) disable iff (!rst_n)
        evt_frame_start |-> capturing);

    // R10: immediate disable idles the block on the next cycle with no strobe
    a_r10_stop_now: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_enable && !cfg_stop_at_frame_end) |=> (!capturing && !wr_en && !evt_frame_end));

    // R11: deferred disable leaves a frame only through a frame end
    a_r11_defer: assert property (@(posedge clk) disable iff (!rst_n)
        (capturing && !cfg_enable && cfg_stop_at_frame_end && !core_rst)
        |=> (capturing || evt_frame_end));

    // R12: core reset while disabled idles the block
    a_r12_core_rst: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_enable && core_rst) |=> !capturing);
endmodule

bind cam_capture cam_capture_chk u_chk (
    .clk                   (clk),
    .rst_n                 (rst_n),
    .cfg_enable            (cfg_enable),
    .cfg_stop_at_frame_end (cfg_stop_at_frame_end),
    .core_rst              (core_rst),
    .wr_en                 (wr_en),
    .capturing             (capturing),
    .evt_frame_start       (evt_frame_start),
    .evt_frame_end         (evt_frame_end),
    .evt_line_start        (evt_line_start),
    .evt_line_end          (evt_line_end)
);

// File: tb/cam_capture_test.sv
module cam_capture_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cam_pclk = 1'b0;
    logic        cam_vsync = 1'b0;
    logic        cam_hsync = 1'b0;
    logic [7:0]  cam_data = '0;
    logic        cfg_enable = 1'b0;
    logic        cfg_stop_at_frame_end = 1'b0;
    logic        cfg_start_on_edge = 1'b1;
    logic        cfg_vs_low = 1'b0;
    logic        cfg_hs_low = 1'b0;
    logic        cfg_pclk_fall = 1'b0;
    logic        cfg_swap = 1'b0;
    logic        core_rst = 1'b0;
    logic [31:0] wr_data;
    logic        wr_en;
    logic        capturing;
    logic        evt_frame_start;
    logic        evt_frame_end;
    logic        evt_line_start;
    logic        evt_line_end;

    always #2.5 clk = ~clk;

    cam_capture uut (
        .clk(clk), .rst_n(rst_n), .cam_pclk(cam_pclk), .cam_vsync(cam_vsync),
        .cam_hsync(cam_hsync), .cam_data(cam_data), .cfg_enable(cfg_enable),
        .cfg_stop_at_frame_end(cfg_stop_at_frame_end), .cfg_start_on_edge(cfg_start_on_edge),
        .cfg_vs_low(cfg_vs_low), .cfg_hs_low(cfg_hs_low), .cfg_pclk_fall(cfg_pclk_fall),
        .cfg_swap(cfg_swap), .core_rst(core_rst), .wr_data(wr_data), .wr_en(wr_en),
        .capturing(capturing), .evt_frame_start(evt_frame_start), .evt_frame_end(evt_frame_end),
        .evt_line_start(evt_line_start), .evt_line_end(evt_line_end)
    );

    // item kinds: 0 frame start, 1 line start, 2 word, 3 line end, 4 frame end
    typedef struct {
        int          kind;
        logic [31:0] data;
        string       req;
    } item_t;

    item_t exp_q[$];
    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;
    string cur_req = "R2";

    // reference model state
    bit       m_frame = 0;
    bit       m_pv = 0;
    bit       m_ph = 0;
    int       m_cnt = 0;
    bit [7:0] m_b [4];
    byte unsigned seq = 8'h10;

    function automatic string kname(int k);
        case (k)
            0: return "frame_start";
            1: return "line_start";
            2: return "word";
            3: return "line_end";
            default: return "frame_end";
        endcase
    endfunction

    task automatic chk(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic push(int kind, logic [31:0] data);
        item_t it;
        it.kind = kind;
        it.data = data;
        it.req  = cur_req;
        exp_q.push_back(it);
    endtask

    task automatic observe(int kind, logic [31:0] data);
        item_t it;
        if (exp_q.size() == 0) begin
            chk(1'b0, cur_req, {"unexpected ", kname(kind)}, data, 32'h0);
        end else begin
            it = exp_q.pop_front();
            chk(it.kind == kind && (kind != 2 || it.data == data), it.req,
                {kname(kind), " vs expected ", kname(it.kind)}, data, it.data);
        end
    endtask

    // monitor: compare in fixed order within one cycle
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (evt_frame_start) observe(0, 32'h0);
            if (evt_line_start)  observe(1, 32'h0);
            if (wr_en)           observe(2, wr_data);
            if (evt_line_end)    observe(3, 32'h0);
            if (evt_frame_end)   observe(4, 32'h0);
        end
    end

    task automatic model_step(bit vs, bit hs, bit [7:0] d);
        int slot;
        if (!m_frame) begin
            if (cfg_enable && (cfg_start_on_edge ? (vs && !m_pv) : vs)) begin
                m_frame = 1;
                push(0, 32'h0);
            end
        end else if (!vs) begin
            m_frame = 0;
            m_cnt = 0;
            push(4, 32'h0);
        end
        if (m_frame && vs) begin
            if (hs && !m_ph) begin push(1, 32'h0); m_cnt = 0; end
            if (!hs && m_ph) begin push(3, 32'h0); m_cnt = 0; end
            if (hs) begin
                slot = cfg_swap ? 3 - m_cnt : m_cnt;
                m_b[slot] = d;
                m_cnt++;
                if (m_cnt == 4) begin
                    push(2, {m_b[3], m_b[2], m_b[1], m_b[0]});
                    m_cnt = 0;
                end
            end
        end
        m_pv = vs;
        m_ph = hs;
    endtask

    // one pixel-clock period carrying active-level sync values
    task automatic send(bit vs, bit hs);
        seq = seq + 8'd1;
        model_step(vs, hs, seq);
        cam_vsync = vs ^ cfg_vs_low;
        cam_hsync = hs ^ cfg_hs_low;
        cam_data  = seq;
        cam_pclk  = cfg_pclk_fall;
        repeat (2) @(negedge clk);
        cam_pclk  = ~cfg_pclk_fall;
        repeat (2) @(negedge clk);
    endtask

    task automatic line(int n);
        for (int i = 0; i < n; i++) send(1, 1);
        send(1, 0);
    endtask

    task automatic frame(int lines, int n);
        send(0, 0);
        send(1, 0);
        for (int i = 0; i < lines; i++) line(n);
        send(0, 0);
    endtask

    task automatic drained(string req);
        repeat (2) @(negedge clk);
        chk(exp_q.size() == 0, req, "pending expected items", exp_q.size(), 0);
    endtask

    task automatic idle_cfg();
        cfg_enable = 0;
        @(negedge clk);
        m_frame = 0;
        m_cnt = 0;
        cam_vsync = cfg_vs_low;
        cam_hsync = cfg_hs_low;
        cam_pclk  = cfg_pclk_fall;
        repeat (2) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(!wr_en && !capturing && !evt_frame_start && !evt_frame_end &&
            !evt_line_start && !evt_line_end && wr_data == 0, "R1", "outputs in reset",
            {wr_en, capturing, evt_frame_start, evt_frame_end, evt_line_start, evt_line_end}, 0);
        rst_n = 1;
        repeat (2) @(negedge clk);
        chk(!wr_en && !capturing && wr_data == 0, "R1", "outputs after reset", wr_data, 0);

        // R2 R6: basic frames, blanking bytes not packed
        cur_req = "R2"; cfg_enable = 1; @(negedge clk);
        frame(2, 8);
        drained("R2");
        cur_req = "R6"; frame(3, 4);
        drained("R6");

        // R7: partial word dropped
        cur_req = "R7"; frame(2, 6);
        drained("R7");

        // R3: swap
        cur_req = "R3"; cfg_swap = 1; frame(2, 8); drained("R3"); cfg_swap = 0;

        // R4: active-low syncs
        cur_req = "R4"; cfg_vs_low = 1; cfg_hs_low = 1; idle_cfg(); cfg_enable = 1;
        frame(2, 8); drained("R4");
        cfg_vs_low = 0; cfg_hs_low = 0; idle_cfg();

        // R5: falling-edge sampling
        cur_req = "R5"; cfg_pclk_fall = 1; idle_cfg(); cfg_enable = 1;
        frame(1, 12); drained("R5");
        cfg_pclk_fall = 0; idle_cfg();

        // R8: level start with sync already active
        cur_req = "R8"; cfg_start_on_edge = 0;
        send(1, 0); send(1, 0);
        cfg_enable = 1; @(negedge clk);
        line(8); send(0, 0);
        drained("R8");
        idle_cfg();

        // R9: edge start ignores an already active level
        cur_req = "R9"; cfg_start_on_edge = 1;
        send(1, 0);
        cfg_enable = 1; @(negedge clk);
        line(8);
        chk(!capturing, "R9", "capturing with sync already active", capturing, 0);
        send(0, 0); send(1, 0); line(4); send(0, 0);
        drained("R9");

        // R10: immediate disable
        cur_req = "R10"; cfg_stop_at_frame_end = 0;
        send(0, 0); send(1, 0); send(1, 1); send(1, 1);
        cfg_enable = 0; @(negedge clk);
        m_frame = 0; m_cnt = 0;
        chk(!capturing, "R10", "capturing after immediate disable", capturing, 0);
        line(8); send(0, 0);
        drained("R10");
        cfg_enable = 1; @(negedge clk);

        // R11: deferred disable
        cur_req = "R11"; cfg_stop_at_frame_end = 1;
        send(0, 0); send(1, 0); send(1, 1);
        cfg_enable = 0; @(negedge clk);
        chk(capturing, "R11", "capturing during deferred disable", capturing, 1);
        send(1, 1); send(1, 1); send(1, 1); send(1, 0);
        line(4); send(0, 0);
        chk(!capturing, "R11", "capturing after frame end", capturing, 0);
        frame(1, 4);
        drained("R11");

        // R12: core reset ignored while enabled, honoured while disabled
        cur_req = "R12"; cfg_enable = 1; @(negedge clk);
        send(0, 0); send(1, 0); send(1, 1); send(1, 1);
        core_rst = 1; @(negedge clk); core_rst = 0; @(negedge clk);
        chk(capturing, "R12", "core reset while enabled", capturing, 1);
        send(1, 1); send(1, 1); send(1, 0);
        cfg_enable = 0; @(negedge clk);
        send(1, 1);
        core_rst = 1; @(negedge clk); core_rst = 0; @(negedge clk);
        m_frame = 0; m_cnt = 0;
        chk(!capturing, "R12", "core reset while disabled", capturing, 0);
        line(8); send(0, 0);
        drained("R12");

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    end
endmodule